// File: doc/BRIEF.md
# Floating-Point Adder/Subtractor

A purely combinational unit that adds or subtracts two IEEE 754 binary floating-point words. A single width parameter selects half (16-bit), single (32-bit) or double (64-bit) precision. The unit first decodes both operands and applies the requested operation to the sign of the second operand. It then aligns the smaller magnitude to the larger one, keeping guard, round and sticky bits. It adds or subtracts the significands, normalizes, rounds to nearest with ties to even, and packs the result.

Two enable inputs choose the operation. Subtract wins whenever it is asserted. Add applies only when subtract is low. With both low, the output is forced to all zeros. Infinities and NaNs are handled by the usual IEEE rules. Subnormal inputs are read as zero, and results below the normal range flush to a signed zero. No flags are produced and there is no clock.

Top module: `fp_addsub`

## Requirements
- R1: Parameter FW of 16, 32 or 64 selects the format with sign at bit FW-1, then an exponent field of 5, 8 or 11 bits, then a fraction field of 10, 23 or 52 bits in the low bits; the half format computes 1.0+2.0=3.0 (0x3C00+0x4000=0x4200).
- R2: When sub_en is 1, result equals op_a minus op_b, whatever the value of add_en.
- R3: When add_en is 1 and sub_en is 0, result equals op_a plus op_b, including operands of opposite sign.
- R4: When add_en and sub_en are both 0, result is all zeros, whatever the operands.
- R5: The exact result is rounded to the nearest representable value, with an exact tie going to the neighbour whose fraction LSB is 0; alignment shifts of any distance keep the bits needed for this.
- R6: An effective subtraction of two equal finite magnitudes gives +0 (all zeros).
- R7: A rounded result whose exponent reaches the all-ones code gives an infinity of the result's sign (exponent all ones, fraction zero).
- R8: An operand with a zero exponent field counts as zero, and a result below the smallest normal magnitude gives a zero carrying the result's sign.
- R9: A NaN on either operand gives the quiet NaN with sign 0, exponent all ones, fraction MSB 1 and other fraction bits 0 (0x7FC00000 in single).
- R10: Infinity minus an infinity of the same sign (after the operation is applied) gives that quiet NaN; an infinity combined with a finite value returns the infinity with its effective sign.
- R11: x plus zero returns x (zero minus x returns -x); the sum of two zeros is -0 only when both effective signs are negative, otherwise +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | FW | First operand |
| op_b | input | FW | Second operand |
| add_en | input | 1 | Add enable, effective only when sub_en is 0 |
| sub_en | input | 1 | Subtract enable, takes priority over add_en |
| result | output | FW | Rounded sum or difference, or zero when idle |

## Verification
The assertions judge only settled, fully known input values; any X or Z on the operands or enables skips them. That matters because the block has no clock, and its inputs are undefined before the first stimulus. The bench changes every input together on a rising clock edge and reads the result on the falling edge, so each check sees settled logic. The stimulus uses hand-picked encodings: exact ties, long and short alignment shifts, cancellation, the largest finite value, values near the smallest normal, subnormal, infinity and NaN patterns. Both the single and half formats are covered.

// File: rtl/fp_addsub.sv
module fp_addsub #(
  parameter int FW = 32
) (
  input  logic [FW-1:0] op_a,
  input  logic [FW-1:0] op_b,
  input  logic          add_en,
  input  logic          sub_en,
  output logic [FW-1:0] result
);
  localparam int EW = (FW == 16) ? 5 : (FW == 32) ? 8 : 11;
  localparam int MW = FW - 1 - EW;
  localparam int SW = MW + 1;
  localparam int XW = SW + 3;
  localparam int LW = $clog2(XW + 1);
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [FW-1:0] QNAN = {1'b0, EMAX, 1'b1, {(MW-1){1'b0}}};

  function automatic logic [LW-1:0] lzc(input logic [XW-1:0] v);
    lzc = LW'(XW);
    for (int i = 0; i < XW; i++)
      if (v[i]) lzc = LW'(XW - 1 - i);
  endfunction

  logic          sa, sb;
  logic [EW-1:0] ea, eb;
  logic [MW-1:0] ma, mb;
  logic          za, zb, ia, ib, na, nb;

  assign sa = op_a[FW-1];
  assign sb = op_b[FW-1] ^ sub_en;
  assign ea = op_a[FW-2:MW];
  assign eb = op_b[FW-2:MW];
  assign ma = op_a[MW-1:0];
  assign mb = op_b[MW-1:0];
  assign za = (ea == '0);
  assign zb = (eb == '0);
  assign ia = (ea == EMAX) && (ma == '0);
  assign ib = (eb == EMAX) && (mb == '0);
  assign na = (ea == EMAX) && (ma != '0);
  assign nb = (eb == EMAX) && (mb != '0);

  logic          swap, s_big, eff_sub;
  logic [EW-1:0] e_big, e_sml, diff;
  logic [XW-1:0] x_big, x_sml, al;

  assign swap    = op_b[FW-2:0] > op_a[FW-2:0];
  assign s_big   = swap ? sb : sa;
  assign e_big   = swap ? eb : ea;
  assign e_sml   = swap ? ea : eb;
  assign x_big   = {1'b1, (swap ? mb : ma), 3'b000};
  assign x_sml   = {1'b1, (swap ? ma : mb), 3'b000};
  assign diff    = e_big - e_sml;
  assign eff_sub = sa ^ sb;

  always_comb begin
    if (int'(diff) >= XW) begin
      al = '0;
      al[0] = 1'b1;
    end else begin
      al = x_sml >> diff;
      al[0] = al[0] | (|(x_sml & ((XW'(1) << diff) - XW'(1))));
    end
  end

  logic [XW:0]      sum;
  logic [LW-1:0]    lz;
  logic [XW-2:0]    nrm;
  logic [EW+1:0]    e1, e2;
  logic             uf, up, of;
  logic [EW+MW+1:0] pk;
  logic [FW-1:0]    fin;

  assign sum = eff_sub ? ({1'b0, x_big} - {1'b0, al}) : ({1'b0, x_big} + {1'b0, al});
  assign lz  = lzc(sum[XW-1:0]);

  always_comb begin
    if (sum[XW]) begin
      nrm = {sum[XW-1:2], sum[1] | sum[0]};
      e1  = {2'b00, e_big} + (EW+2)'(1);
      uf  = 1'b0;
    end else begin
      nrm = (XW-1)'(sum[XW-1:0] << lz);
      e1  = {2'b00, e_big} - (EW+2)'(lz);
      uf  = {2'b00, e_big} <= (EW+2)'(lz);
    end
  end

  assign up = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
  assign pk = {e1, nrm[XW-2:3]} + (EW+MW+2)'(up);
  assign e2 = pk[EW+MW+1:MW];
  assign of = e2 >= {2'b00, EMAX};

  always_comb begin
    if (sum == '0)  fin = '0;
    else if (uf)    fin = {s_big, {(FW-1){1'b0}}};
    else if (of)    fin = {s_big, EMAX, {MW{1'b0}}};
    else            fin = {s_big, e2[EW-1:0], pk[MW-1:0]};
  end

  always_comb begin
    if (!(add_en | sub_en))  result = '0;
    else if (na | nb)        result = QNAN;
    else if (ia & ib)        result = (sa == sb) ? {sa, EMAX, {MW{1'b0}}} : QNAN;
    else if (ia)             result = {sa, EMAX, {MW{1'b0}}};
    else if (ib)             result = {sb, EMAX, {MW{1'b0}}};
    else if (za & zb)        result = {sa & sb, {(FW-1){1'b0}}};
    else if (za)             result = {sb, op_b[FW-2:0]};
    else if (zb)             result = op_a;
    else                     result = fin;
  end
endmodule

module fp_addsub_chk #(
  parameter int FW = 32
) (
  input logic [FW-1:0] op_a,
  input logic [FW-1:0] op_b,
  input logic          add_en,
  input logic          sub_en,
  input logic [FW-1:0] result
);
  localparam int EW = (FW == 16) ? 5 : (FW == 32) ? 8 : 11;
  localparam int MW = FW - 1 - EW;

  logic a_fin, a_nan, a_inf, b_zero, act;
  assign a_fin  = op_a[FW-2:MW] != '1;
  assign a_nan  = !a_fin && (op_a[MW-1:0] != '0);
  assign a_inf  = !a_fin && (op_a[MW-1:0] == '0);
  assign b_zero = op_b[FW-2:MW] == '0;
  assign act    = add_en | sub_en;

  always_comb begin
    if (!$isunknown({op_a, op_b, add_en, sub_en})) begin
      // R4
      idle_zero_chk: assert (act || result == '0);
      // R6
      self_cancel_chk: assert (!(sub_en && op_a == op_b && a_fin) || result == '0);
      // R9
      nan_in_chk: assert (!(act && a_nan) || (result[FW-2:MW] == '1 && result[MW-1]));
      // R10
      inf_cancel_chk: assert (!(sub_en && op_a == op_b && a_inf) || (result[FW-2:MW] == '1 && result[MW-1]));
      // R11
      add_zero_chk: assert (!(add_en && !sub_en && b_zero && a_fin && op_a[FW-2:MW] != '0) || result == op_a);
    end
  end
endmodule

bind fp_addsub fp_addsub_chk #(.FW(FW)) chk_i (
  .op_a(op_a), .op_b(op_b), .add_en(add_en), .sub_en(sub_en), .result(result)
);

// File: tb/fp_addsub_test.sv
module fp_addsub_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a, b;
  logic        ad, sb;
  logic [31:0] y;
  logic [15:0] ha, hb;
  logic        had, hsb;
  logic [15:0] hy;
  int checks = 0, fails = 0;
  bit done = 0;

  fp_addsub #(.FW(32)) uut   (.op_a(a),  .op_b(b),  .add_en(ad),  .sub_en(sb),  .result(y));
  fp_addsub #(.FW(16)) uut_h (.op_a(ha), .op_b(hb), .add_en(had), .sub_en(hsb), .result(hy));

  task automatic chk32(input logic [31:0] x, input logic [31:0] z, input logic e_add, input logic e_sub,
                       input logic [31:0] exp, input string rq);
    @(posedge clk);
    a <= x; b <= z; ad <= e_add; sb <= e_sub;
    @(negedge clk);
    checks++;
    if (y !== exp) begin
      fails++;
      $display("FAIL %s: %h op %h got %h expected %h", rq, x, z, y, exp);
    end
  endtask

  task automatic chk16(input logic [15:0] x, input logic [15:0] z, input logic e_add, input logic e_sub,
                       input logic [15:0] exp, input string rq);
    @(posedge clk);
    ha <= x; hb <= z; had <= e_add; hsb <= e_sub;
    @(negedge clk);
    checks++;
    if (hy !== exp) begin
      fails++;
      $display("FAIL %s: %h op %h got %h expected %h", rq, x, z, hy, exp);
    end
  endtask

  task automatic t_idle;
    chk32(32'h3F800000, 32'h40000000, 0, 0, 32'h00000000, "R4");
    chk32(32'h7FC00001, 32'hFF800000, 0, 0, 32'h00000000, "R4");
  endtask

  task automatic t_add;
    chk32(32'h3F800000, 32'h40000000, 1, 0, 32'h40400000, "R3");
    chk32(32'h3FC00000, 32'h3FC00000, 1, 0, 32'h40400000, "R3");
    chk32(32'h40400000, 32'hBF800000, 1, 0, 32'h40000000, "R3");
  endtask

  task automatic t_sub;
    chk32(32'h40400000, 32'h3F800000, 1, 1, 32'h40000000, "R2");
    chk32(32'h3F800000, 32'h40000000, 0, 1, 32'hBF800000, "R2");
    chk32(32'h3F800000, 32'hBF800000, 1, 1, 32'h40000000, "R2");
  endtask

  task automatic t_round;
    chk32(32'h3F800000, 32'h33800000, 1, 0, 32'h3F800000, "R5");
    chk32(32'h3F800001, 32'h33800000, 1, 0, 32'h3F800002, "R5");
    chk32(32'h3F800000, 32'h33C00000, 1, 0, 32'h3F800001, "R5");
    chk32(32'h3F800000, 32'h30800000, 1, 0, 32'h3F800000, "R5");
  endtask

  task automatic t_cancel;
    chk32(32'h3FC00000, 32'h3FC00000, 0, 1, 32'h00000000, "R6");
    chk32(32'hBFC00000, 32'hBFC00000, 0, 1, 32'h00000000, "R6");
    chk32(32'h3FC00000, 32'hBFC00000, 1, 0, 32'h00000000, "R6");
  endtask

  task automatic t_overflow;
    chk32(32'h7F7FFFFF, 32'h7F7FFFFF, 1, 0, 32'h7F800000, "R7");
    chk32(32'hFF7FFFFF, 32'hFF7FFFFF, 1, 0, 32'hFF800000, "R7");
  endtask

  task automatic t_flush;
    chk32(32'h00800001, 32'h00800000, 0, 1, 32'h00000000, "R8");
    chk32(32'h00800000, 32'h00800001, 0, 1, 32'h80000000, "R8");
    chk32(32'h3F800000, 32'h00000001, 1, 0, 32'h3F800000, "R8");
  endtask

  task automatic t_nan;
    chk32(32'h7FC00001, 32'h3F800000, 1, 0, 32'h7FC00000, "R9");
    chk32(32'h3F800000, 32'hFF800001, 0, 1, 32'h7FC00000, "R9");
  endtask

  task automatic t_inf;
    chk32(32'h7F800000, 32'h7F800000, 0, 1, 32'h7FC00000, "R10");
    chk32(32'h7F800000, 32'hFF800000, 1, 0, 32'h7FC00000, "R10");
    chk32(32'h7F800000, 32'h3F800000, 1, 0, 32'h7F800000, "R10");
    chk32(32'h3F800000, 32'h7F800000, 0, 1, 32'hFF800000, "R10");
  endtask

  task automatic t_zero;
    chk32(32'h3F800000, 32'h00000000, 1, 0, 32'h3F800000, "R11");
    chk32(32'h80000000, 32'h80000000, 1, 0, 32'h80000000, "R11");
    chk32(32'h00000000, 32'h80000000, 1, 0, 32'h00000000, "R11");
    chk32(32'h00000000, 32'h3F800000, 0, 1, 32'hBF800000, "R11");
  endtask

  task automatic t_half;
    chk16(16'h3C00, 16'h4000, 1, 0, 16'h4200, "R1");
    chk16(16'h3C00, 16'h4000, 0, 1, 16'hBC00, "R1");
    chk16(16'h7BFF, 16'h7BFF, 1, 0, 16'h7C00, "R1");
    chk16(16'h7C01, 16'h3C00, 1, 0, 16'h7E00, "R1");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    t_idle();
    t_add();
    t_sub();
    t_round();
    t_cancel();
    t_overflow();
    t_flush();
    t_nan();
    t_inf();
    t_zero();
    t_half();
    done = 1;
    summary();
  end
endmodule